// File: doc/BRIEF.md
# Memory Card Read Sequencer

This block runs the reader side of a contactless memory card dump. It does not touch the radio itself. It issues requests to an external frame transmitter, an external frame receiver and an external delay timer, and it watches a free-running tick count kept by the transceiver. Each card byte costs one full powered session. The carrier is switched on and held for a short charge delay. A fixed setup exchange then tells the sequencer which kind of card is present. On a read session a masked address command follows, the masked reply is unmasked, and the byte is written out. At the end the carrier is dropped for a long delay so that the tag forgets its state.

The first session after `startReq` only identifies the card. The type code selects three things: the card size, the command length and the reply mask. Every later session repeats the setup exchange. If the type reported in a later session differs from the first one, the card is taken to have been removed. A read ends for one of four reasons: every byte has been stored, an unknown type was seen, a removal was detected, or an abort arrived. In each case `done` is raised, and `error` marks the two failure endings.

Top module: `cardReadSeq`

## Requirements
- R1: Every session begins with `carrierOn` high and a short delay request (`dlySel` = 0, 1 ms) before any frame is requested.
- R2: The setup exchange in each session is, in order: transmit 0x55 as 7 bits, receive 6 bits, transmit 0x19 as 6 bits. The 0x19 frame is requested only once `tickCnt` has reached `GAP_TICKS`.
- R3: The card type is the low 6 bits of the setup reply XOR 0x26. Type 0x1D selects 256 bytes, a 9-bit command and reply mask 0x52. Type 0x3D selects 1024 bytes, an 11-bit command and reply mask 0xD4. The identified type is shown on `cardType`, which reads 0 when no type has been accepted.
- R4: An identification reply with any other type ends the run after the power-off delay, with `done`=1, `error`=1 and no write.
- R5: The read command word is 0x57 XOR (byte address << 1), with the bit count chosen by the type. It is requested only once `tickCnt` has reached `GAP_TICKS` after the setup exchange.
- R6: After the command, 8 reply bits are requested. One cycle after `rxDone`, a one-cycle `wrEn` pulse carries `wrData` = reply XOR mask at `wrAddr`. Addresses run from 0 upward.
- R7: Each session, including the identifying one, ends with `carrierOn` low and a long delay request (`dlySel` = 1, 10 ms).
- R8: A later session whose setup reply gives a different type skips the command, powers off and ends with `done`=1, `error`=1.
- R9: After the last byte of the card has been stored, `done` rises two cycles after the final `dlyDone`, with `error`=0.
- R10: `abortReq` while running lets the current session finish and then ends the run with `done`=1 and `error`=0. `abortReq` while idle has no effect.
- R11: After reset, `carrierOn`, `done`, `error`, `wrEn` and all request outputs are low, and `cardType` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Begin a card read (accepted when idle) |
| abortReq | input | 1 | Stop after the current session |
| carrierOn | output | 1 | Field carrier enable |
| txReq | output | 1 | One-cycle transmit request |
| txData | output | 16 | Frame word, sent LSB first |
| txBits | output | 5 | Number of bits to transmit |
| txDone | input | 1 | Transmit finished pulse |
| rxReq | output | 1 | One-cycle receive request |
| rxBits | output | 5 | Number of bits to receive |
| rxDone | input | 1 | Receive finished pulse |
| rxData | input | 8 | Received bits, valid with `rxDone` |
| tickCnt | input | TICK_W | Transceiver tick count, restarted at each frame end |
| dlyReq | output | 1 | One-cycle delay request |
| dlySel | output | 1 | 0: 1 ms charge, 1: 10 ms power-off |
| dlyDone | input | 1 | Delay elapsed pulse |
| wrEn | output | 1 | Byte write strobe |
| wrAddr | output | ADDR_W | Byte address |
| wrData | output | 8 | Unmasked byte |
| done | output | 1 | Run finished (held until next start) |
| error | output | 1 | Run ended on unknown type or removal |
| cardType | output | 6 | Identified type code |

## Verification
Every request is compared against an expected transaction queue in the negedge after the one cycle in which it is visible. Each handshake is answered three cycles later. The write pulse is checked to land exactly one cycle after the `rxDone` that carried its reply. `done` is checked to rise exactly two cycles after the last `dlyDone`. The gap rule is checked by sampling the bench-owned tick count at the moment each 0x19 or command request appears. That count restarts at every frame completion.

// File: rtl/cardSeqPkg.sv
package cardSeqPkg;
  localparam int FRAME_W = 16;
  localparam int NBITS_W = 5;
  localparam int TYPE_W  = 6;

  localparam logic [FRAME_W-1:0] HELLO_WORD = 16'h0055;
  localparam logic [NBITS_W-1:0] HELLO_LEN  = 5'd7;
  localparam logic [FRAME_W-1:0] ACK_WORD   = 16'h0019;
  localparam logic [NBITS_W-1:0] ACK_LEN    = 5'd6;
  localparam logic [NBITS_W-1:0] TYPE_LEN   = 5'd6;
  localparam logic [NBITS_W-1:0] BYTE_LEN   = 5'd8;
  localparam logic [TYPE_W-1:0]  TYPE_KEY   = 6'h26;
  localparam logic [FRAME_W-1:0] CMD_KEY    = 16'h0057;

  localparam logic [TYPE_W-1:0]  SMALL_ID      = 6'h1D;
  localparam logic [TYPE_W-1:0]  LARGE_ID      = 6'h3D;
  localparam logic [7:0]         SMALL_MASK    = 8'h52;
  localparam logic [7:0]         LARGE_MASK    = 8'hD4;
  localparam logic [NBITS_W-1:0] SMALL_CMD_LEN = 5'd9;
  localparam logic [NBITS_W-1:0] LARGE_CMD_LEN = 5'd11;
  localparam int                 SMALL_BYTES   = 256;
  localparam int                 LARGE_BYTES   = 1024;

  typedef enum logic [1:0] {FR_HELLO, FR_ACK, FR_CMD} frameSel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHARGE, ST_HELLO, ST_TYPE, ST_GAP1, ST_ACK,
    ST_CHECK, ST_GAP2, ST_CMD, ST_BYTE, ST_OFF, ST_FIN
  } seqState_e;

  typedef struct packed {
    logic      clrAddr;
    logic      grabType;
    logic      keepType;
    logic      storeByte;
    frameSel_e txSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/cardSeqData.sv
module cardSeqData
  import cardSeqPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [7:0]          rxData,
  output logic [FRAME_W-1:0]  txData,
  output logic [NBITS_W-1:0]  txBits,
  output logic                typeKnown,
  output logic                typeSame,
  output logic                lastByte,
  output logic                wrEn,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [7:0]          wrData,
  output logic [TYPE_W-1:0]   cardType
);
  localparam logic [ADDR_W-1:0] SMALL_LAST = ADDR_W'(SMALL_BYTES - 1);
  localparam logic [ADDR_W-1:0] LARGE_LAST = ADDR_W'(LARGE_BYTES - 1);

  if (ADDR_W < 10 || ADDR_W > FRAME_W - 1) begin : g_addrWidthBad
    $error("cardSeqData: ADDR_W must cover 1024 bytes and fit the command word");
  end

  logic [TYPE_W-1:0]  sessType;
  logic [TYPE_W-1:0]  idType;
  logic [ADDR_W-1:0]  addr;
  logic [TYPE_W-1:0]  rxType;
  logic               isLarge;
  logic [7:0]         respMask;
  logic [NBITS_W-1:0] cmdLen;
  logic [ADDR_W-1:0]  lastAddr;
  logic [FRAME_W-1:0] cmdWord;

  assign rxType    = rxData[TYPE_W-1:0] ^ TYPE_KEY;
  assign isLarge   = (idType == LARGE_ID);
  assign respMask  = isLarge ? LARGE_MASK : SMALL_MASK;
  assign cmdLen    = isLarge ? LARGE_CMD_LEN : SMALL_CMD_LEN;
  assign lastAddr  = isLarge ? LARGE_LAST : SMALL_LAST;
  assign cmdWord   = CMD_KEY ^ (FRAME_W'(addr) << 1);
  assign typeKnown = (sessType == SMALL_ID) || (sessType == LARGE_ID);
  assign typeSame  = (sessType == idType);
  assign lastByte  = (addr == lastAddr);
  assign cardType  = idType;

  always_comb begin
    case (strb.txSel)
      FR_ACK:  begin txData = ACK_WORD;   txBits = ACK_LEN;   end
      FR_CMD:  begin txData = cmdWord;    txBits = cmdLen;    end
      default: begin txData = HELLO_WORD; txBits = HELLO_LEN; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sessType <= '0;
      idType   <= '0;
      addr     <= '0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      if (strb.grabType) sessType <= rxType;
      if (strb.clrAddr) begin
        idType <= '0;
        addr   <= '0;
      end else begin
        if (strb.keepType)  idType <= sessType;
        if (strb.storeByte) addr <= addr + 1'b1;
      end
      wrEn <= strb.storeByte;
      if (strb.storeByte) begin
        wrAddr <= addr;
        wrData <= rxData ^ respMask;
      end
    end
  end

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R3
  wr_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (cardType == SMALL_ID || cardType == LARGE_ID));

  // R6
  wr_ascend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn, 1) == 1'b0 && wrAddr != '0) |-> (addr == wrAddr + 1'b1));
endmodule

// File: rtl/cardSeqCtrl.sv
module cardSeqCtrl
  import cardSeqPkg::*;
#(
  parameter int TICK_W    = 12,
  parameter int GAP_TICKS = 387
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               abortReq,
  input  logic               txDone,
  input  logic               rxDone,
  input  logic               dlyDone,
  input  logic [TICK_W-1:0]  tickCnt,
  input  logic               typeKnown,
  input  logic               typeSame,
  input  logic               lastByte,
  output ctrlStrobe_t        strb,
  output logic               txReq,
  output logic               rxReq,
  output logic [NBITS_W-1:0] rxBits,
  output logic               dlyReq,
  output logic               dlySel,
  output logic               carrierOn,
  output logic               done,
  output logic               error
);
  localparam logic [TICK_W-1:0] GAP_LIMIT = TICK_W'(GAP_TICKS);

  seqState_e state, nxt;
  logic issued, firstRun, failPend, stopPend, abortPend;
  logic actState, fire, gapMet, stopNow;

  assign gapMet   = (tickCnt >= GAP_LIMIT);
  assign actState = state inside {ST_CHARGE, ST_HELLO, ST_TYPE, ST_ACK,
                                  ST_CMD, ST_BYTE, ST_OFF};
  assign fire     = actState && !issued;
  assign txReq    = fire && (state inside {ST_HELLO, ST_ACK, ST_CMD});
  assign rxReq    = fire && (state inside {ST_TYPE, ST_BYTE});
  assign dlyReq   = fire && (state inside {ST_CHARGE, ST_OFF});
  assign dlySel   = (state == ST_OFF);
  assign rxBits   = (state == ST_BYTE) ? BYTE_LEN : TYPE_LEN;
  assign carrierOn = !(state inside {ST_IDLE, ST_OFF, ST_FIN});
  assign stopNow  = failPend || stopPend || abortPend;

  always_comb begin
    nxt  = state;
    strb = '0;
    strb.txSel = FR_HELLO;
    case (state)
      ST_IDLE:   if (startReq) begin strb.clrAddr = 1'b1; nxt = ST_CHARGE; end
      ST_CHARGE: if (issued && dlyDone) nxt = ST_HELLO;
      ST_HELLO:  if (issued && txDone) nxt = ST_TYPE;
      ST_TYPE:   if (issued && rxDone) begin strb.grabType = 1'b1; nxt = ST_GAP1; end
      ST_GAP1:   if (gapMet) nxt = ST_ACK;
      ST_ACK: begin
        strb.txSel = FR_ACK;
        if (issued && txDone) nxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (firstRun) begin
          strb.keepType = typeKnown;
          nxt = ST_OFF;
        end else begin
          nxt = typeSame ? ST_GAP2 : ST_OFF;
        end
      end
      ST_GAP2:   if (gapMet) nxt = ST_CMD;
      ST_CMD: begin
        strb.txSel = FR_CMD;
        if (issued && txDone) nxt = ST_BYTE;
      end
      ST_BYTE:   if (issued && rxDone) begin strb.storeByte = 1'b1; nxt = ST_OFF; end
      ST_OFF:    if (issued && dlyDone) nxt = stopNow ? ST_FIN : ST_CHARGE;
      ST_FIN:    nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      issued    <= 1'b0;
      firstRun  <= 1'b0;
      failPend  <= 1'b0;
      stopPend  <= 1'b0;
      abortPend <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      state  <= nxt;
      issued <= (nxt == state) && (issued || fire);
      if (state == ST_IDLE && startReq) begin
        firstRun  <= 1'b1;
        failPend  <= 1'b0;
        stopPend  <= 1'b0;
        abortPend <= 1'b0;
        done      <= 1'b0;
        error     <= 1'b0;
      end else begin
        if (abortReq && state != ST_IDLE) abortPend <= 1'b1;
        if (state == ST_CHECK && firstRun && !typeKnown) failPend <= 1'b1;
        if (state == ST_CHECK && !firstRun && !typeSame) failPend <= 1'b1;
        if (state == ST_BYTE && issued && rxDone && lastByte) stopPend <= 1'b1;
        if (state == ST_OFF && nxt == ST_CHARGE) firstRun <= 1'b0;
        if (state == ST_FIN) begin
          done  <= 1'b1;
          error <= failPend;
        end
      end
    end
  end

  // R1
  charge_carrier_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dlyReq && !dlySel) |-> carrierOn);

  // R7
  off_carrier_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dlyReq && dlySel) |-> !carrierOn);

  // R2
  gap_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && strb.txSel != FR_HELLO) |-> (tickCnt >= GAP_LIMIT));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!carrierOn && !txReq && !rxReq && !dlyReq));

  // R4
  error_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);
endmodule

// File: rtl/cardReadSeq.sv
module cardReadSeq
  import cardSeqPkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int TICK_W    = 12,
  parameter int GAP_TICKS = 387
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              abortReq,
  output logic              carrierOn,
  output logic              txReq,
  output logic [15:0]       txData,
  output logic [4:0]        txBits,
  input  logic              txDone,
  output logic              rxReq,
  output logic [4:0]        rxBits,
  input  logic              rxDone,
  input  logic [7:0]        rxData,
  input  logic [TICK_W-1:0] tickCnt,
  output logic              dlyReq,
  output logic              dlySel,
  input  logic              dlyDone,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              done,
  output logic              error,
  output logic [5:0]        cardType
);
  ctrlStrobe_t strb;
  logic typeKnown, typeSame, lastByte;

  cardSeqCtrl #(.TICK_W(TICK_W), .GAP_TICKS(GAP_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .txDone(txDone), .rxDone(rxDone), .dlyDone(dlyDone), .tickCnt(tickCnt),
    .typeKnown(typeKnown), .typeSame(typeSame), .lastByte(lastByte),
    .strb(strb), .txReq(txReq), .rxReq(rxReq), .rxBits(rxBits),
    .dlyReq(dlyReq), .dlySel(dlySel), .carrierOn(carrierOn),
    .done(done), .error(error)
  );

  cardSeqData #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rxData(rxData),
    .txData(txData), .txBits(txBits), .typeKnown(typeKnown),
    .typeSame(typeSame), .lastByte(lastByte), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .cardType(cardType)
  );
endmodule

// File: tb/sim_cardReadSeq.sv
module sim_cardReadSeq;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 12;
  localparam int LAT        = 3;

  localparam logic [2:0] EV_CHG = 3'd1, EV_OFF = 3'd2, EV_TX = 3'd3,
                         EV_RX  = 3'd4, EV_WR  = 3'd5;
  typedef struct packed { logic [2:0] kind; logic [15:0] a; logic [15:0] b; } ev_t;

  logic clk = 0, rstN = 0, startReq = 0, abortReq = 0;
  logic txDone = 0, rxDone = 0, dlyDone = 0;
  logic [7:0] rxData = 0;
  logic [11:0] tickCnt = 0;
  logic carrierOn, txReq, rxReq, dlyReq, dlySel, wrEn, done, error;
  logic [15:0] txData;
  logic [4:0] txBits, rxBits;
  logic [9:0] wrAddr;
  logic [7:0] wrData;
  logic [5:0] cardType;

  always #(CLK_PERIOD/2) clk = ~clk;

  cardReadSeq #(.ADDR_W(10), .TICK_W(12), .GAP_TICKS(GAP)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .carrierOn(carrierOn), .txReq(txReq), .txData(txData), .txBits(txBits),
    .txDone(txDone), .rxReq(rxReq), .rxBits(rxBits), .rxDone(rxDone),
    .rxData(rxData), .tickCnt(tickCnt), .dlyReq(dlyReq), .dlySel(dlySel),
    .dlyDone(dlyDone), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .done(done), .error(error), .cardType(cardType)
  );

  int checks = 0, errors = 0;
  ev_t expQ[$];
  int cyc = 0, pend = 0, pendKind = 0, offCyc = 0, rxCyc = 0;
  int sessIdx = 0, typeCode = 0, changeSess = -1, abortAt = -1, wrCount = 0;
  logic [7:0] pendResp = 0;
  bit wantAbort = 0, doneSeen = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int pat(int a);
    return (a * 37 + 5 + (a >> 8) * 3) & 255;
  endfunction
  function automatic int maskOf(int t);
    return (t == 'h3D) ? 'hD4 : 'h52;
  endfunction
  function automatic int cmdLenOf(int t);
    return (t == 'h3D) ? 11 : 9;
  endfunction

  function automatic ev_t mk(logic [2:0] k, int a, int b);
    ev_t e;
    e.kind = k; e.a = 16'(a); e.b = 16'(b);
    return e;
  endfunction

  task automatic pushSetup();
    expQ.push_back(mk(EV_CHG, 0, 0));
    expQ.push_back(mk(EV_TX, 'h55, 7));
    expQ.push_back(mk(EV_RX, 0, 6));
    expQ.push_back(mk(EV_TX, 'h19, 6));
  endtask

  // Environment: transceiver, timer and card, plus per-clock comparison
  initial begin
    forever begin
      bit hit;
      ev_t e;
      @(negedge clk);
      hit = 0;
      cyc++;
      txDone = 0; rxDone = 0; dlyDone = 0;
      if (!rstN) begin
        pend = 0;
      end else begin
        if (tickCnt != 12'hFFF) tickCnt = tickCnt + 1'b1;
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            case (pendKind)
              1: begin txDone = 1; tickCnt = 0; end
              2: begin rxDone = 1; rxData = pendResp; tickCnt = 0; rxCyc = cyc; end
              3: dlyDone = 1;
              default: begin dlyDone = 1; offCyc = cyc; end
            endcase
          end
        end
        if (done && !doneSeen) begin
          // R9: done two cycles after the last power-off delay ends
          check(cyc - offCyc == 2, "R9", "done latency", cyc - offCyc, 2);
        end
        doneSeen = done;
        if ((txReq || rxReq || dlyReq) && pend != 0)
          check(0, "R2", "request during open handshake", 1, 0);
        if (wrEn) begin
          e = (expQ.size() > 0) ? expQ.pop_front() : '0;
          wrCount++;
          check(e.kind == EV_WR, "R6", "unexpected write", int'(wrAddr), int'(e.a));
          check(int'(wrAddr) == int'(e.a), "R6", "write address", int'(wrAddr), int'(e.a));
          check(int'(wrData) == int'(e.b), "R6", "write data", int'(wrData), int'(e.b));
          check(cyc == rxCyc + 1, "R6", "write timing", cyc - rxCyc, 1);
          if (int'(wrAddr) == abortAt) hit = 1;
        end
        if (dlyReq) begin
          e = (expQ.size() > 0) ? expQ.pop_front() : '0;
          if (!dlySel) begin
            sessIdx++;
            check(e.kind == EV_CHG, "R1", "charge delay order", 32'(e.kind), 32'(EV_CHG));
            check(carrierOn == 1'b1, "R1", "carrier during charge", carrierOn, 1);
            pendKind = 3;
          end else begin
            check(e.kind == EV_OFF, "R7", "power-off order", 32'(e.kind), 32'(EV_OFF));
            check(carrierOn == 1'b0, "R7", "carrier during power-off", carrierOn, 0);
            pendKind = 4;
          end
          pend = LAT;
        end
        if (txReq) begin
          e = (expQ.size() > 0) ? expQ.pop_front() : '0;
          check(e.kind == EV_TX, "R2", "transmit order", 32'(e.kind), 32'(EV_TX));
          if (e.b == 6 || e.b == 7) begin
            check(txData == e.a, "R2", "setup frame", int'(txData), int'(e.a));
            check(int'(txBits) == int'(e.b), "R2", "setup length", int'(txBits), int'(e.b));
            if (e.a == 'h19)
              check(int'(tickCnt) >= GAP, "R2", "gap before 0x19", int'(tickCnt), GAP);
          end else begin
            check(txData == e.a, "R5", "command word", int'(txData), int'(e.a));
            check(int'(txBits) == int'(e.b), "R3", "command length", int'(txBits), int'(e.b));
            check(int'(tickCnt) >= GAP, "R5", "gap before command", int'(tickCnt), GAP);
          end
          check(carrierOn == 1'b1, "R2", "carrier during frame", carrierOn, 1);
          pendKind = 1; pend = LAT;
        end
        if (rxReq) begin
          e = (expQ.size() > 0) ? expQ.pop_front() : '0;
          check(e.kind == EV_RX, "R2", "receive order", 32'(e.kind), 32'(EV_RX));
          check(int'(rxBits) == int'(e.b), (e.b == 8) ? "R6" : "R2", "receive length",
                int'(rxBits), int'(e.b));
          if (rxBits == 5'd6) begin
            int code;
            code = (changeSess >= 0 && sessIdx - 1 >= changeSess) ? (typeCode ^ 'h20) : typeCode;
            pendResp = 8'((code ^ 'h26) & 'h3F);
          end else begin
            pendResp = 8'(pat(int'(e.a)) ^ maskOf(typeCode));
          end
          pendKind = 2; pend = LAT;
        end
      end
      abortReq = wantAbort || hit;
    end
  end

  task automatic runCase(string tag, int code, int chg, int abAt, int nWr,
                         bit failTail, bit expErr, int expType);
    typeCode = code; changeSess = chg; abortAt = abAt; sessIdx = 0; wrCount = 0;
    pushSetup();
    expQ.push_back(mk(EV_OFF, 0, 0));
    for (int n = 0; n < nWr; n++) begin
      pushSetup();
      expQ.push_back(mk(EV_TX, ('h57 ^ (n << 1)) & 'hFFFF, cmdLenOf(code)));
      expQ.push_back(mk(EV_RX, n, 8));
      expQ.push_back(mk(EV_WR, n, pat(n)));
      expQ.push_back(mk(EV_OFF, 0, 0));
    end
    if (failTail) begin
      pushSetup();
      expQ.push_back(mk(EV_OFF, 0, 0));
    end
    @(negedge clk); startReq = 1;
    @(negedge clk); startReq = 0;
    check(done == 1'b0, tag, "done cleared by start", done, 0);
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
    check(error == expErr, tag, "error flag", error, expErr);
    check(int'(cardType) == expType, "R3", "card type", int'(cardType), expType);
    check(expQ.size() == 0, tag, "transactions left", expQ.size(), 0);
    check(wrCount == nWr, tag, "write count", wrCount, nWr);
    expQ.delete();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check(carrierOn == 0, "R11", "carrier after reset", carrierOn, 0);
    check(done == 0 && error == 0, "R11", "done/error after reset", {done, error}, 0);
    check(!txReq && !rxReq && !dlyReq && !wrEn, "R11", "requests after reset",
          {txReq, rxReq, dlyReq, wrEn}, 0);
    check(cardType == 0, "R11", "type after reset", int'(cardType), 0);
    // R10 abort while idle: no requests (queue empty) and done stays low
    wantAbort = 1; @(negedge clk); wantAbort = 0;
    repeat (6) @(negedge clk);
    check(done == 0 && carrierOn == 0, "R10", "idle abort effect", {done, carrierOn}, 0);
    // R9, R3: full small card
    runCase("R9", 'h1D, -1, -1, 256, 0, 0, 'h1D);
    // R4: unknown type
    runCase("R4", 'h2A, -1, -1, 0, 0, 1, 0);
    // R8: removal seen in session 5 of a large card
    runCase("R8", 'h3D, 5, -1, 4, 1, 1, 'h3D);
    // R10: abort after byte 9
    runCase("R10", 'h1D, -1, 9, 10, 0, 0, 'h1D);
    // R9, R3: full large card
    runCase("R9", 'h3D, -1, -1, 1024, 0, 0, 'h3D);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule